// File: doc/BRIEF.md
# Direction-Latching Open-Drain Repeater

This block joins a host-side open-drain data line to a card-side open-drain data line and carries one low level at a time across it, half-duplex. It sees the sampled level of each pad and drives a pull-down enable for each pad. Pull-up sources, slew detection and voltage translation are handled elsewhere. Three copies can serve a main data line and two auxiliary lines.

No pin sets the direction. From the idle condition, with both lines high, the first side seen low becomes the input side. The repeater then pulls the other side low. It never passes a low back toward the input side. When the input side lets go, the repeater stops driving. It then waits with both pull-downs released until both synchronised levels read high, and only then returns to idle. A line that is slowly rising, or that is still held low from outside, therefore cannot start a new transfer.

The channel moves nothing unless the enable input and the supply-ready input are both high. If either is low, both pull-downs are released. The card pad then rests at logic one through its pull-up, and the host pad is left undriven.

Top module: `halfduplex_od_repeater`

## Requirements
- R1: After reset, host_pull_o and card_pull_o are both 0 (1 means the pad is pulled low).
- R2: With the block enabled and idle, a low on host_pad_i that is held for more than SYNC_STAGES cycles sets card_pull_o to 1. This happens SYNC_STAGES+1 rising edges after the first edge that samples the low. card_pull_o stays 1 while host_pad_i stays low.
- R3: With the block enabled and idle, a low on card_pad_i alone sets host_pull_o to 1 after the same latency. host_pull_o stays 1 while card_pad_i stays low.
- R4: If both pads are first seen low in the same cycle, the host side becomes the input side, so card_pull_o is set and host_pull_o stays 0.
- R5: The two pull-down outputs are never both 1. While a direction is held, the input side's pull-down stays 0 whatever level the output side has.
- R6: When the input side returns high, the output pull-down is released. Neither pull-down is then driven for at least one cycle, and the block goes back to idle only once both synchronised levels read high.
- R7: If the output side is held low from outside after the input side is released, nothing is driven toward the input side. A fresh transfer can start only after both lines have been high.
- R8: In a collision, where the output side is pulled low from outside during a transfer, the first side may return high as soon as it is released. The other side is no longer driven once the input side releases.
- R9: While en_i is 0, both pull-downs are 0, so the card pad idles at logic one and the host pad is undriven, and any held direction is dropped.
- R10: While ready_i is 0, both pull-downs stay 0 and no low is passed in either direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Channel enable |
| ready_i | input | 1 | Card supply stable |
| host_pad_i | input | 1 | Sampled level of the host-side pad |
| card_pad_i | input | 1 | Sampled level of the card-side pad |
| host_pull_o | output | 1 | Pull host pad low |
| card_pull_o | output | 1 | Pull card pad low |

## Verification
Two things can fall in the same cycle. Both pads can first be seen low on the same edge, so direction arbitration meets a start from either side. The end of a transfer can also meet an outside low on the output side, so the settle wait meets a collision. The bench provokes the first by dropping both line models on the same cycle. It provokes the second by asserting the card-side outside low during a host-driven transfer and holding it past the host release. A behavioural model with queued synchronisers judges each case on every clock, and spot checks confirm which pull-down is set and that the settle period keeps both released.

// File: rtl/odr_pkg.sv
package odr_pkg;

  typedef enum logic [1:0] {
    DIR_IDLE   = 2'd0,
    DIR_H2C    = 2'd1,
    DIR_C2H    = 2'd2,
    DIR_SETTLE = 2'd3
  } dir_state_e;

  // Next direction state from the gated, synchronised line levels.
  function automatic dir_state_e dir_next(dir_state_e cur, logic gate,
                                          logic host_hi, logic card_hi);
    dir_state_e nxt;
    nxt = cur;
    if (!gate) begin
      nxt = DIR_IDLE;
    end else begin
      case (cur)
        DIR_IDLE: begin
          if (!host_hi)      nxt = DIR_H2C;   // host wins a tie
          else if (!card_hi) nxt = DIR_C2H;
        end
        DIR_H2C:    if (host_hi) nxt = DIR_SETTLE;
        DIR_C2H:    if (card_hi) nxt = DIR_SETTLE;
        DIR_SETTLE: if (host_hi && card_hi) nxt = DIR_IDLE;
        default:    nxt = DIR_IDLE;
      endcase
    end
    return nxt;
  endfunction

endpackage

// File: rtl/odr_sync.sv
module odr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[LAST-1:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain[LAST];
endmodule

// File: rtl/odr_dir_fsm.sv
module odr_dir_fsm
  import odr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gate_i,
  input  logic       host_hi_i,
  input  logic       card_hi_i,
  output logic       host_pull_o,
  output logic       card_pull_o,
  output dir_state_e state_o
);
  dir_state_e state_q, state_d;

  // Named events for the checks below
  logic start_h2c, start_c2h, in_settle, tie_seen;

  assign state_d   = dir_next(state_q, gate_i, host_hi_i, card_hi_i);
  assign start_h2c = (state_q == DIR_IDLE) && (state_d == DIR_H2C);
  assign start_c2h = (state_q == DIR_IDLE) && (state_d == DIR_C2H);
  assign in_settle = (state_q == DIR_SETTLE);
  assign tie_seen  = gate_i && (state_q == DIR_IDLE) && !host_hi_i && !card_hi_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= DIR_IDLE;
    else        state_q <= state_d;
  end

  assign card_pull_o = gate_i && (state_q == DIR_H2C);
  assign host_pull_o = gate_i && (state_q == DIR_C2H);
  assign state_o     = state_q;

  // R5: never both pads pulled
  p_one_side_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_pull_o, card_pull_o}));

  // R4: a tie resolves toward the host as input
  p_tie_host_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tie_seen |=> (state_q == DIR_H2C));

  // R6: settle drives nothing
  p_settle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_settle |-> (!host_pull_o && !card_pull_o));

  // R9/R10: a closed gate drops any held direction
  p_gate_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_i |=> (state_q == DIR_IDLE));

  // R2: the card pull only rises out of idle or when the gate reopens
  p_card_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_pull_o) |-> ($past(state_q) == DIR_IDLE || !$past(gate_i)));

  // R7: settle exits only to idle
  p_settle_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_settle && gate_i) |=> (state_q == DIR_SETTLE || state_q == DIR_IDLE));

  logic unused_starts;
  assign unused_starts = start_h2c ^ start_c2h;
endmodule

// File: rtl/halfduplex_od_repeater.sv
module halfduplex_od_repeater #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic ready_i,
  input  logic host_pad_i,
  input  logic card_pad_i,
  output logic host_pull_o,
  output logic card_pull_o
);
  import odr_pkg::*;

  localparam int LANES = 2;

  logic [LANES-1:0] pad_raw, pad_hi;
  dir_state_e       state;
  logic             gate;

  assign pad_raw = {card_pad_i, host_pad_i};
  assign gate    = en_i && ready_i;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_sync
      odr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pad_raw[i]),
        .q_o   (pad_hi[i])
      );
    end
  endgenerate

  odr_dir_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate_i      (gate),
    .host_hi_i   (pad_hi[0]),
    .card_hi_i   (pad_hi[1]),
    .host_pull_o (host_pull_o),
    .card_pull_o (card_pull_o),
    .state_o     (state)
  );

  // R1: pulls released right after reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!host_pull_o && !card_pull_o));

  // R10: supply not ready means nothing is passed
  p_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |=> (state == DIR_IDLE));
endmodule

// File: tb/halfduplex_od_repeater_bench.sv
`timescale 1ns/1ps
module halfduplex_od_repeater_bench;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, rdy = 1'b0;
  logic host_ext = 1'b0, card_ext = 1'b0;
  logic host_pull, card_pull;
  logic host_pad, card_pad;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  assign host_pad = !(host_ext || host_pull);
  assign card_pad = !(card_ext || card_pull);

  halfduplex_od_repeater #(.SYNC_STAGES(SYNC)) u_halfduplex_od_repeater (
    .clk(clk), .rst_n(rst_n), .en_i(en), .ready_i(rdy),
    .host_pad_i(host_pad), .card_pad_i(card_pad),
    .host_pull_o(host_pull), .card_pull_o(card_pull)
  );

  // Behavioural reference: 0 idle, 1 host drives card, 2 card drives host, 3 settle
  int  mode = 0;
  bit  hq[$], cq[$];
  bit  s_h = 1, s_c = 1, s_en = 0, s_rdy = 0;

  initial begin
    for (int i = 0; i < SYNC; i++) begin hq.push_back(1); cq.push_back(1); end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      mode = 0;
      hq = {}; cq = {};
      for (int i = 0; i < SYNC; i++) begin hq.push_back(1); cq.push_back(1); end
    end else begin
      bit h, c;
      h = hq[0]; c = cq[0];
      if (!(s_en && s_rdy)) mode = 0;
      else if (mode == 0) begin
        if (!h) mode = 1; else if (!c) mode = 2;
      end else if (mode == 1) begin
        if (h) mode = 3;
      end else if (mode == 2) begin
        if (c) mode = 3;
      end else if (h && c) mode = 0;
      void'(hq.pop_front()); hq.push_back(s_h);
      void'(cq.pop_front()); cq.push_back(s_c);
    end
  end

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic ec, eh;
    ec = (mode == 1) && en && rdy;
    eh = (mode == 2) && en && rdy;
    chk(cur_req, card_pull, ec, "model card_pull");
    chk(cur_req, host_pull, eh, "model host_pull");
    s_h = host_pad; s_c = card_pad; s_en = en; s_rdy = rdy;
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    cyc(3);
    cur_req = "R1";
    chk("R1", host_pull, 1'b0, "reset host_pull");
    chk("R1", card_pull, 1'b0, "reset card_pull");
    rst_n = 1'b1; en = 1'b1; rdy = 1'b1;
    cyc(3);

    cur_req = "R2";
    host_ext = 1'b1;
    cyc(SYNC + 1);
    chk("R2", card_pull, 1'b1, "card pulled after host low");
    cyc(4);
    chk("R2", card_pull, 1'b1, "card pull held");
    cur_req = "R6";
    host_ext = 1'b0;
    cyc(SYNC + 1);
    chk("R6", card_pull, 1'b0, "released after host release");
    chk("R6", host_pull, 1'b0, "no drive in settle");
    cyc(6);

    cur_req = "R3";
    card_ext = 1'b1;
    cyc(SYNC + 1);
    chk("R3", host_pull, 1'b1, "host pulled after card low");
    chk("R5", card_pull, 1'b0, "no echo toward card");
    card_ext = 1'b0;
    cyc(8);

    cur_req = "R4";
    host_ext = 1'b1; card_ext = 1'b1;
    cyc(SYNC + 2);
    chk("R4", card_pull, 1'b1, "tie host wins card pull");
    chk("R4", host_pull, 1'b0, "tie host not pulled");
    card_ext = 1'b0;
    cyc(2);
    host_ext = 1'b0;
    cyc(8);

    cur_req = "R7";
    host_ext = 1'b1;
    cyc(SYNC + 2);
    card_ext = 1'b1;
    cyc(2);
    host_ext = 1'b0;
    cyc(8);
    chk("R7", host_pull, 1'b0, "held output side not echoed");
    chk("R7", card_pull, 1'b0, "output released");
    card_ext = 1'b0;
    cyc(8);

    cur_req = "R8";
    host_ext = 1'b1;
    cyc(SYNC + 2);
    card_ext = 1'b1;
    cyc(1);
    host_ext = 1'b0;
    cyc(1);
    card_ext = 1'b0;
    cyc(SYNC + 2);
    chk("R8", card_pull, 1'b0, "collision output released");
    chk("R8", host_pull, 1'b0, "collision nothing to host");
    cyc(6);

    cur_req = "R9";
    host_ext = 1'b1;
    cyc(SYNC + 2);
    en = 1'b0;
    #0.5;
    chk("R9", card_pull, 1'b0, "disable releases card");
    cyc(3);
    chk("R9", host_pull, 1'b0, "disable host undriven");
    host_ext = 1'b0;
    cyc(4);
    en = 1'b1;
    cyc(6);

    cur_req = "R10";
    rdy = 1'b0;
    card_ext = 1'b1;
    cyc(6);
    chk("R10", host_pull, 1'b0, "not ready blocks card low");
    card_ext = 1'b0;
    host_ext = 1'b1;
    cyc(6);
    chk("R10", card_pull, 1'b0, "not ready blocks host low");
    host_ext = 1'b0;
    rdy = 1'b1;
    cyc(8);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule